// File: doc/BRIEF.md
# Health-Test Self-Check Sequencer

This block drives a one-time self-test of the health-test circuitry that watches a random-number noise source. When software raises a force request while the generator is enabled, the sequencer injects faults in two phases. In the first phase it switches off the noise sub-sources one at a time, in ascending index order. Each sub-source stays off long enough for the repetition-count health test to report a failure. In the second phase it puts every sub-source into a degraded, low-entropy mode and holds them there until the proportion health test reports a failure. It then returns the noise source to normal operation.

During the whole sequence the block marks generated data as not random. The feature is usable once per reset. A force request that arrives while the generator is disabled does not start a run and does not use up that single run. The health tests and the noise cells themselves sit outside this block. Their failure flags are inputs here, and the disable and degrade controls are outputs.

Top module: `ht_selftest_seq`

## Requirements
- R1: After reset, `src_disable` is all zeros, `degrade_all` is 0 and `data_invalid` is 0.
- R2: A run starts at a clock edge where `force_req`=1 and `gen_en`=1 and no run has started since reset. From the next cycle, `src_disable` equals 1 (bit 0 set) and `data_invalid` is 1.
- R3: At most one bit of `src_disable` is set at any time. The set bit moves only from index i to index i+1, starting at index 0.
- R4: Each sub-source stays disabled for at least DWELL cycles. It is released at the first edge that meets both conditions: the dwell has elapsed, and `rep_fail` has been sampled at 1 at some edge since that slot began (that edge included). A flag pulse seen before the dwell ends is remembered.
- R5: One cycle after the last sub-source (index NUM_SRC-1) is released, `src_disable` is all zeros and `degrade_all` is 1. A 1 on `prop_fail` during the rotation phase has no effect.
- R6: The degrade phase ends at the first edge where `prop_fail` is sampled at 1. In the next cycle `degrade_all` is 0. `rep_fail` has no effect during this phase.
- R7: A `force_req` sampled while `gen_en`=0 is ignored, leaves all outputs at 0, and does not use up the one allowed run.
- R8: Once a run has started, every later `force_req` is ignored until reset. This applies both during the run (the sequence does not restart) and after it ends (no new run).
- R9: `data_invalid` is 1 from the cycle after the accepted request through the cycle in which `prop_fail` is sampled, and it is 1 whenever a sub-source is disabled or degraded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_en | input | 1 | Generator enabled |
| force_req | input | 1 | Self-test force request, sampled each cycle |
| rep_fail | input | 1 | Repetition-count health-test failure flag |
| prop_fail | input | 1 | Proportion health-test failure flag |
| src_disable | output | NUM_SRC | Per-sub-source disable, one-hot or zero |
| degrade_all | output | 1 | All sub-sources in low-entropy mode |
| data_invalid | output | 1 | Output data must be treated as not random |

## Verification
The bench builds the block with NUM_SRC=3 and DWELL=5. With these values the bench can walk every sub-source slot, the step from the last slot into the degrade phase, and the minimum dwell boundary, all in a few dozen cycles. The short dwell means the bench can also hold a slot well past its minimum when no repetition flag arrives. It can also place a flag pulse inside the dwell window to exercise the remembered-flag path. Separate resets per scenario let the bench exercise the one-run lockout against both a disabled-generator request and a completed run.

// File: rtl/ht_selftest_pkg.sv
// Package: shared types for the health-test self-check sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ht_selftest_pkg;

    // Sequencer phase: idle, rotating single-source disables, all-source degrade.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ROTATE  = 2'd1,
        PH_DEGRADE = 2'd2
    } phase_e;

endpackage

// File: rtl/ht_cmd_gate.sv
// Module: ht_cmd_gate
// Accepts a self-test force request only while the generator is enabled,
// the sequencer is idle and no run has been started since reset.
// Assumes: force_req is sampled each cycle; rst_n is synchronous, active low.
module ht_cmd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_en,
    input  logic force_req,
    input  logic seq_idle,
    output logic start
);

    logic used_q;

    // Qualify the request: enabled generator, idle sequencer, lockout not spent.
    always_comb begin
        start = force_req && gen_en && seq_idle && !used_q;
    end

    // One-shot lockout: set by the first accepted request, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= 1'b0;
        end else if (start) begin
            used_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ht_slot_timer.sv
// Module: ht_slot_timer
// Times one sub-source disable slot. Reports ready once the slot has lasted
// DWELL cycles and the repetition flag has been seen at any edge in the slot.
// Assumes: DWELL >= 2; clear is pulsed at the edge that opens a slot.
module ht_slot_timer #(
    parameter int DWELL = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic flag,
    output logic ready
);

    localparam int CNT_W = $clog2(DWELL);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             seen_q;
    logic             dwell_done;

    // Dwell is complete once the counter has saturated at its last value.
    always_comb begin
        dwell_done = (cnt_q == LAST);
        ready      = run && dwell_done && (seen_q || flag);
    end

    // Count slot cycles (saturating) and remember any flag sighting.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (run) begin
            if (!dwell_done) begin
                cnt_q <= cnt_q + 1'b1;
            end
            seen_q <= seen_q || flag;
        end
    end

endmodule

// File: rtl/ht_phase_fsm.sv
// Module: ht_phase_fsm
// Phase controller: steps the disabled sub-source index upward through all
// sources, then holds the degrade phase until the proportion flag is seen.
// Assumes: NUM_SRC >= 1; start only arrives while idle.
module ht_phase_fsm
    import ht_selftest_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             slot_ready,
    input  logic             prop_fail,
    output phase_e           phase,
    output logic [IDX_W-1:0] idx,
    output logic             slot_clear
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

    phase_e           phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // Next-phase and next-index logic, plus the slot-open pulse.
    always_comb begin
        phase_d    = phase_q;
        idx_d      = idx_q;
        slot_clear = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d    = PH_ROTATE;
                    idx_d      = '0;
                    slot_clear = 1'b1;
                end
            end
            PH_ROTATE: begin
                if (slot_ready) begin
                    if (idx_q == LAST_IDX) begin
                        phase_d = PH_DEGRADE;
                        idx_d   = '0;
                    end else begin
                        idx_d      = idx_q + 1'b1;
                        slot_clear = 1'b1;
                    end
                end
            end
            PH_DEGRADE: begin
                if (prop_fail) begin
                    phase_d = PH_IDLE;
                end
            end
            default: begin
                phase_d = PH_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    // Phase and index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end

    assign phase = phase_q;
    assign idx   = idx_q;

endmodule

// File: rtl/ht_selftest_seq.sv
// Module: ht_selftest_seq (top)
// Health-test self-check sequencer: on an accepted force request it disables
// sub-sources one at a time until the repetition flag is seen for each, then
// degrades all sub-sources until the proportion flag is seen, then returns to
// normal. Usable once per reset.
// Assumes: NUM_SRC >= 1, DWELL >= 2; health flags are synchronous to clk.
module ht_selftest_seq
    import ht_selftest_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DWELL   = 2048
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gen_en,
    input  logic               force_req,
    input  logic               rep_fail,
    input  logic               prop_fail,
    output logic [NUM_SRC-1:0] src_disable,
    output logic               degrade_all,
    output logic               data_invalid
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic             start;
    logic             slot_clear;
    logic             slot_ready;
    logic             rotating;

    assign rotating = (phase == PH_ROTATE);

    ht_cmd_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_en    (gen_en),
        .force_req (force_req),
        .seq_idle  (phase == PH_IDLE),
        .start     (start)
    );

    ht_slot_timer #(
        .DWELL (DWELL)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (slot_clear),
        .run   (rotating),
        .flag  (rep_fail),
        .ready (slot_ready)
    );

    ht_phase_fsm #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .slot_ready (slot_ready),
        .prop_fail  (prop_fail),
        .phase      (phase),
        .idx        (idx),
        .slot_clear (slot_clear)
    );

    // Per-source disable decode: one line per sub-source.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_disable[g] = rotating && (idx == IDX_W'(g));
    end

    // Degrade control and not-random marking follow the phase.
    always_comb begin
        degrade_all  = (phase == PH_DEGRADE);
        data_invalid = (phase != PH_IDLE);
    end

endmodule

// File: rtl/ht_selftest_chk.sv
// Module: ht_selftest_chk
// Assertion checker for ht_selftest_seq, attached by bind.
// Assumes: same parameters as the bound instance.
module ht_selftest_chk #(
    parameter int NUM_SRC = 4,
    parameter int DWELL   = 2048
) (
    input logic               clk,
    input logic               rst_n,
    input logic               gen_en,
    input logic               force_req,
    input logic               rep_fail,
    input logic               prop_fail,
    input logic [NUM_SRC-1:0] src_disable,
    input logic               degrade_all,
    input logic               data_invalid
);

    localparam int HOLD_W = $clog2(DWELL + 1) + 1;

    logic [NUM_SRC-1:0] prev_off;
    logic [HOLD_W-1:0]  hold;
    logic               prev_inv;
    logic               ran;

    // Track how long the current disable pattern has been held, and run completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_off <= '0;
            hold     <= '0;
            prev_inv <= 1'b0;
            ran      <= 1'b0;
        end else begin
            prev_off <= src_disable;
            prev_inv <= data_invalid;
            if (src_disable != prev_off) begin
                hold <= HOLD_W'(1);
            end else if (hold != '1) begin
                hold <= hold + 1'b1;
            end
            if (prev_inv && !data_invalid) begin
                ran <= 1'b1;
            end
        end
    end

    a_r3_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_disable));

    a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_off != '0 && src_disable != '0 && src_disable != prev_off)
        |-> (src_disable == (prev_off << 1)));

    a_r4_min_dwell: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_off != '0 && src_disable != prev_off) |-> (hold >= HOLD_W'(DWELL)));

    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        degrade_all |-> (src_disable == '0));

    a_r6_exit_on_prop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(degrade_all) |-> $past(prop_fail));

    a_r7_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_invalid && force_req && !gen_en) |=> !data_invalid);

    a_r8_single_run: assert property (@(posedge clk) disable iff (!rst_n)
        ran |-> !data_invalid);

    a_r9_invalid_cover: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_disable != '0) || degrade_all) |-> data_invalid);

endmodule

bind ht_selftest_seq ht_selftest_chk #(
    .NUM_SRC (NUM_SRC),
    .DWELL   (DWELL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gen_en       (gen_en),
    .force_req    (force_req),
    .rep_fail     (rep_fail),
    .prop_fail    (prop_fail),
    .src_disable  (src_disable),
    .degrade_all  (degrade_all),
    .data_invalid (data_invalid)
);

// File: tb/ht_selftest_seq_tb.sv
// Bench: directed scenarios for ht_selftest_seq, one task each.
// Inputs change and outputs are checked at falling edges.
module ht_selftest_seq_tb;

    localparam int NS = 3;
    localparam int DW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gen_en = 1'b0;
    logic          force_req = 1'b0;
    logic          rep_fail = 1'b0;
    logic          prop_fail = 1'b0;
    logic [NS-1:0] src_disable;
    logic          degrade_all;
    logic          data_invalid;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ht_selftest_seq #(.NUM_SRC(NS), .DWELL(DW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .gen_en       (gen_en),
        .force_req    (force_req),
        .rep_fail     (rep_fail),
        .prop_fail    (prop_fail),
        .src_disable  (src_disable),
        .degrade_all  (degrade_all),
        .data_invalid (data_invalid)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        tick();
        rst_n = 1'b0; gen_en = 1'b0; force_req = 1'b0;
        rep_fail = 1'b0; prop_fail = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    // R1: outputs idle after reset.
    task automatic t_reset();
        do_reset();
        chk("R1", "src_disable", 32'(src_disable), 32'h0);
        chk("R1", "degrade_all", 32'(degrade_all), 32'h0);
        chk("R1", "data_invalid", 32'(data_invalid), 32'h0);
    endtask

    // R7: request with generator off is ignored and keeps the run available.
    task automatic t_disabled_force();
        do_reset();
        force_req = 1'b1;
        tick();
        force_req = 1'b0;
        tick();
        chk("R7", "data_invalid after gated request", 32'(data_invalid), 32'h0);
        chk("R7", "src_disable after gated request", 32'(src_disable), 32'h0);
        gen_en = 1'b1;
        force_req = 1'b1;
        tick();
        force_req = 1'b0;
        chk("R7", "run still available: src_disable", 32'(src_disable), 32'h1);
    endtask

    // R2..R6, R8, R9: full run with repetition flag held high.
    task automatic t_full_run();
        do_reset();
        gen_en = 1'b1;
        rep_fail = 1'b1;
        force_req = 1'b1;
        tick();
        force_req = 1'b0;
        chk("R2", "first disable", 32'(src_disable), 32'h1);
        chk("R9", "invalid at start", 32'(data_invalid), 32'h1);
        for (int s = 0; s < NS; s++) begin
            for (int d = 0; d < DW; d++) begin
                chk("R3", $sformatf("src %0d cycle %0d", s, d),
                    32'(src_disable), 32'(1) << s);
                if (s == 0 && d == 2) prop_fail = 1'b1;
                if (s == 0 && d == 3) prop_fail = 1'b0;
                if (s == 1 && d == 1) force_req = 1'b1;
                if (s == 1 && d == 2) force_req = 1'b0;
                tick();
            end
        end
        chk("R5", "src_disable in degrade", 32'(src_disable), 32'h0);
        chk("R5", "degrade_all entered", 32'(degrade_all), 32'h1);
        tick(); tick(); tick();
        chk("R6", "rep_fail ignored in degrade", 32'(degrade_all), 32'h1);
        chk("R9", "invalid in degrade", 32'(data_invalid), 32'h1);
        prop_fail = 1'b1;
        tick();
        prop_fail = 1'b0;
        rep_fail = 1'b0;
        chk("R6", "degrade_all released", 32'(degrade_all), 32'h0);
        chk("R9", "invalid released", 32'(data_invalid), 32'h0);
        force_req = 1'b1;
        tick();
        force_req = 1'b0;
        tick();
        chk("R8", "no second run: data_invalid", 32'(data_invalid), 32'h0);
        chk("R8", "no second run: src_disable", 32'(src_disable), 32'h0);
    endtask

    // R4: slot waits for the flag past the dwell, and remembers an early pulse.
    task automatic t_late_flag();
        do_reset();
        gen_en = 1'b1;
        force_req = 1'b1;
        tick();
        force_req = 1'b0;
        for (int k = 0; k < 10; k++) begin
            chk("R4", $sformatf("held without flag %0d", k), 32'(src_disable), 32'h1);
            if (k == 9) rep_fail = 1'b1;
            tick();
        end
        rep_fail = 1'b0;
        chk("R4", "advance on late flag", 32'(src_disable), 32'h2);
        tick();
        rep_fail = 1'b1;
        tick();
        rep_fail = 1'b0;
        chk("R4", "early pulse: still slot 1 (a)", 32'(src_disable), 32'h2);
        tick();
        chk("R4", "early pulse: still slot 1 (b)", 32'(src_disable), 32'h2);
        tick();
        chk("R4", "early pulse: still slot 1 (c)", 32'(src_disable), 32'h2);
        tick();
        chk("R4", "remembered pulse advances at dwell", 32'(src_disable), 32'h4);
        rep_fail = 1'b1;
        for (int k = 0; k < DW; k++) tick();
        chk("R5", "degrade after last slot", 32'(degrade_all), 32'h1);
        prop_fail = 1'b1;
        tick();
        prop_fail = 1'b0;
        rep_fail = 1'b0;
        chk("R9", "invalid cleared after prop flag", 32'(data_invalid), 32'h0);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_disabled_force();
        t_full_run();
        t_late_flag();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule